// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block is the device-side logic of a serial flash that handles writes to, and reads from, its 16-bit status word. The word is held as a low byte and a high byte. The host talks to the block over a four-wire serial link in clock-phase mode 0. It can set the write-enable flag, write one or two status bytes, and read either byte back. The serial clock, select and data lines are brought into the system clock domain through synchronizers, and every action is timed by edges seen there.

A status write takes effect only in three cases. The enable flag must have been set when the write opcode arrived. Select must rise exactly after one or two whole data bytes. No self-timed cycle may already be running. When the write is accepted, a busy interval counted in system clock cycles starts. At the end of that interval the enable flag drops. The host can keep polling the busy flag with status reads during the whole interval.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset both status bytes read as 0x00.
- R2: Opcode 0x06 sets the write-enable flag (low byte bit 1) when no self-timed cycle is running.
- R3: Opcode 0x01 is taken as a write only if the write-enable flag is 1 when its eighth bit arrives. Otherwise neither byte changes and no busy cycle starts.
- R4: A status write commits only when select rises after exactly 8 or exactly 16 data bits. Any other count discards it. Protection bits change only on a select rising edge, and busy starts only there.
- R5: The first data byte loads low byte bits 7..2. Its bits 1 and 0 are ignored, because those positions hold the write-enable flag (bit 1) and busy (bit 0).
- R6: On a 16-bit write, high byte bits 1 and 0 take the second data byte's bits 1 and 0. High byte bits 7..2 always read 0.
- R7: On an 8-bit write, high byte bits 1 and 0 are cleared to 0.
- R8: A committed write holds busy at 1 for exactly BUSY_CYCLES system clocks. Busy then returns to 0, and the write-enable flag clears at the same time.
- R9: Opcode 0x05 reads the low byte and 0x35 reads the high byte. Data goes out MSB first, changing after falling serial-clock edges. The byte repeats for as long as select stays low. Reads work while busy. The output is 0 while select is high.
- R10: While busy, every opcode other than the two reads is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Host-to-device serial data |
| miso | output | 1 | Device-to-host serial data |

## Verification
The status word is visible only through serial reads, so a wrong bit-counter value or a wrong armed flag shows up as a status byte that does not match after the next read frame, about 16 serial clocks later. A busy timer of the wrong length shows when a read taken just after the expected end still reports busy or the enable flag. It also shows when a read taken well inside the interval already shows them cleared. Commands that should be ignored are checked by reading back, after the busy interval, exactly the bits they would have changed.

// File: rtl/spi_sr_pkg.sv
`timescale 1ns/1ps
package spi_sr_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SET_WEL   = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_WR_STATUS = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_RD_LOW    = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_RD_HIGH   = 8'h35;

    typedef enum logic [2:0] {
        K_NONE,
        K_SET_WEL,
        K_WRITE,
        K_RD_LOW,
        K_RD_HIGH
    } cmd_kind_e;

    typedef struct packed {
        logic [5:0] prot;
        logic       wel;
        logic       busy;
    } low_reg_t;

    typedef struct packed {
        logic qe;
        logic lock;
    } high_bits_t;

    function automatic cmd_kind_e decode_cmd(input logic [BYTE_W-1:0] op);
        case (op)
            CMD_SET_WEL:   return K_SET_WEL;
            CMD_WR_STATUS: return K_WRITE;
            CMD_RD_LOW:    return K_RD_LOW;
            CMD_RD_HIGH:   return K_RD_HIGH;
            default:       return K_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] high_byte(input high_bits_t h);
        return {6'b0, h.qe, h.lock};
    endfunction

endpackage

// File: rtl/spi_sr_sync.sv
`timescale 1ns/1ps
module spi_sr_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sr_frame.sv
`timescale 1ns/1ps
module spi_sr_frame
    import spi_sr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              sclk_rise,
    input  logic              mosi_bit,
    output logic              op_stb,
    output cmd_kind_e         op_kind,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [BYTE_W-1:0] d_first,
    output logic [BYTE_W-1:0] d_second
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] END_OP   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] END_D1   = CNT_W'(2 * BYTE_W - 1);
    localparam logic [CNT_W-1:0] END_D2   = CNT_W'(3 * BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;
    logic              unused_msb;

    assign sh_next    = {sh_q[BYTE_W-2:0], mosi_bit};
    assign unused_msb = sh_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            bit_cnt  <= '0;
            op_stb   <= 1'b0;
            op_kind  <= K_NONE;
            d_first  <= '0;
            d_second <= '0;
        end else if (!active) begin
            bit_cnt <= '0;
            op_stb  <= 1'b0;
            op_kind <= K_NONE;
        end else begin
            op_stb <= 1'b0;
            if (sclk_rise) begin
                sh_q <= sh_next;
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == END_OP) begin
                    op_kind <= decode_cmd(sh_next);
                    op_stb  <= 1'b1;
                end
                if (bit_cnt == END_D1) d_first  <= sh_next;
                if (bit_cnt == END_D2) d_second <= sh_next;
            end
        end
    end
endmodule

// File: rtl/spi_sr_regs.sv
`timescale 1ns/1ps
module spi_sr_regs
    import spi_sr_pkg::*;
#(
    parameter int BUSY_CYCLES = 256,
    parameter int CNT_W       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_stb,
    input  cmd_kind_e         op_kind,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [BYTE_W-1:0] d_first,
    input  logic [BYTE_W-1:0] d_second,
    output low_reg_t          low_q,
    output high_bits_t        high_q
);
    localparam int               TMR_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] LEN_TWO  = CNT_W'(3 * BYTE_W);

    logic             armed_q;
    logic [TMR_W-1:0] tmr_q;
    logic             unused_bits;

    assign unused_bits = ^{d_first[1:0], d_second[BYTE_W-1:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            high_q  <= '0;
            armed_q <= 1'b0;
            tmr_q   <= '0;
        end else begin
            if (low_q.busy) begin
                if (tmr_q == '0) begin
                    low_q.busy <= 1'b0;
                    low_q.wel  <= 1'b0;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
            end
            if (op_stb && !low_q.busy) begin
                if (op_kind == K_SET_WEL) low_q.wel <= 1'b1;
                armed_q <= (op_kind == K_WRITE) && low_q.wel;
            end
            if (frame_end) begin
                armed_q <= 1'b0;
                if (armed_q && (bit_cnt == LEN_ONE || bit_cnt == LEN_TWO)) begin
                    low_q.prot <= d_first[BYTE_W-1:2];
                    high_q     <= (bit_cnt == LEN_TWO) ? high_bits_t'(d_second[1:0]) : '0;
                    low_q.busy <= 1'b1;
                    tmr_q      <= TMR_W'(BUSY_CYCLES - 1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_sr_tx.sv
`timescale 1ns/1ps
module spi_sr_tx
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              sclk_fall,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              miso
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            idx_q  <= '0;
            snap_q <= '0;
            miso   <= 1'b0;
        end else if (sclk_fall && rd_en) begin
            if (idx_q == '0) begin
                snap_q <= byte_in;
                miso   <= byte_in[BYTE_W-1];
            end else begin
                miso <= snap_q[TOP_IDX - idx_q];
            end
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_sr_ctrl.sv
`timescale 1ns/1ps
module spi_sr_ctrl
    import spi_sr_pkg::*;
#(
    parameter int BUSY_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int FRAME_BITS = 3 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    logic [2:0]        pins_s;
    logic              sclk_s, cs_s, mosi_s;
    logic              sclk_d, cs_d;
    logic              sclk_rise, sclk_fall, cs_rise;
    logic              op_stb;
    cmd_kind_e         op_kind;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] d_first, d_second, rd_byte;
    low_reg_t          status_low;
    high_bits_t        status_high;
    logic              rd_en;

    spi_sr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst), .din({sclk, cs_n, mosi}), .dout(pins_s)
    );
    assign {sclk_s, cs_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_rise   = cs_s & ~cs_d;

    spi_sr_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst(rst), .active(~cs_s), .sclk_rise(sclk_rise),
        .mosi_bit(mosi_s), .op_stb(op_stb), .op_kind(op_kind),
        .bit_cnt(bit_cnt), .d_first(d_first), .d_second(d_second)
    );

    spi_sr_regs #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .op_stb(op_stb), .op_kind(op_kind),
        .frame_end(cs_rise), .bit_cnt(bit_cnt), .d_first(d_first),
        .d_second(d_second), .low_q(status_low), .high_q(status_high)
    );

    assign rd_en   = (op_kind == K_RD_LOW) || (op_kind == K_RD_HIGH);
    assign rd_byte = (op_kind == K_RD_HIGH) ? high_byte(status_high) : status_low;

    spi_sr_tx u_tx (
        .clk(clk), .rst(rst), .active(~cs_s), .sclk_fall(sclk_fall),
        .rd_en(rd_en), .byte_in(rd_byte), .miso(miso)
    );
endmodule

// File: rtl/spi_sr_ctrl_chk.sv
`timescale 1ns/1ps
module spi_sr_ctrl_chk #(
    parameter int BUSY_CYCLES = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_sync,
    input logic       cs_rise,
    input logic       miso,
    input logic       busy,
    input logic       wel,
    input logic [5:0] prot
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= '0;
        else              busy_len <= busy_len + 1'b1;
    end

    assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == 32'(BUSY_CYCLES)));

    assert_wel_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise));

    assert_prot_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(cs_rise) |-> $stable(prot));

    assert_wel_set_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy));

    assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cs_sync) |-> !miso);
endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .cs_sync(cs_s), .cs_rise(cs_rise), .miso(miso),
    .busy(status_low.busy), .wel(status_low.wel), .prot(status_low.prot)
);

// File: tb/tb_spi_sr_ctrl.sv
`timescale 1ns/1ps
module tb_spi_sr_ctrl;
    localparam int BUSY = 1500;
    localparam int HALF = 8;
    localparam int GAP  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    spi_sr_ctrl #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
        rx   = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[nbits-1-i];
            wait_clk(HALF);
            rx   = {rx[30:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(GAP);
    endtask

    task automatic send(input int nbits, input logic [31:0] tx);
        logic [31:0] rx;
        xfer(nbits, tx, rx);
    endtask

    task automatic rd(input logic [7:0] op, output logic [7:0] val);
        logic [31:0] rx;
        xfer(16, {16'h0, op, 8'h00}, rx);
        val = rx[7:0];
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h05, v); chk("R1 low byte after reset", v, 8'h00);
        rd(8'h35, v); chk("R1 high byte after reset", v, 8'h00);
    endtask

    task automatic t_no_wel;
        logic [7:0] v;
        send(24, 32'h0001FCFF);
        rd(8'h05, v); chk("R3 write without enable", v, 8'h00);
        rd(8'h35, v); chk("R3 high byte unchanged", v, 8'h00);
    endtask

    task automatic t_set_wel;
        logic [7:0] v;
        send(8, 32'h06);
        rd(8'h05, v); chk("R2 enable flag set", v, 8'h02);
    endtask

    task automatic t_two_byte;
        logic [31:0] rx;
        logic [7:0]  v;
        send(24, 32'h0001FFFF);
        xfer(24, 32'h00050000, rx);
        chk("R8 busy and enable during cycle", rx[15:8], 8'hFF);
        chk("R9 read repeats while selected", rx[7:0], 8'hFF);
        rd(8'h35, v); chk("R6 high byte read while busy", v, 8'h03);
        wait_clk(BUSY + 200);
        rd(8'h05, v); chk("R8 busy and enable cleared", v, 8'hFC);
        rd(8'h35, v); chk("R6 high byte kept", v, 8'h03);
    endtask

    task automatic t_one_byte;
        logic [7:0] v;
        send(8, 32'h06);
        send(16, 32'h0157);
        wait_clk(BUSY + 200);
        rd(8'h05, v); chk("R5 low bits 1..0 of data ignored", v, 8'h54);
        rd(8'h35, v); chk("R7 short write clears high bits", v, 8'h00);
    endtask

    task automatic t_bad_count;
        logic [7:0] v;
        send(8, 32'h06);
        send(20, 32'h001A8F);
        rd(8'h05, v); chk("R4 12 data bits discarded", v, 8'h56);
        send(32, 32'h01A8FF03);
        rd(8'h05, v); chk("R4 24 data bits discarded", v, 8'h56);
        rd(8'h35, v); chk("R4 high byte untouched", v, 8'h00);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        send(24, 32'h00010403);
        rd(8'h05, v); chk("R9 busy visible to poll", v, 8'h07);
        send(8, 32'h06);
        send(16, 32'h01F8);
        rd(8'h35, v); chk("R6 two byte write high bits", v, 8'h03);
        wait_clk(BUSY + 200);
        rd(8'h05, v); chk("R10 commands during busy ignored", v, 8'h04);
        rd(8'h35, v); chk("R10 high byte kept", v, 8'h03);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        chk("R9 output low when idle", {7'b0, miso}, 8'h00);
        t_reset();
        t_no_wel();
        t_set_wel();
        t_two_byte();
        t_one_byte();
        t_bad_count();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule